// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block builds a 20-bit physical memory address out of a 16-bit segment and a 16-bit offset. It holds four 16-bit segment registers, written one at a time through an indexed write port. A select input chooses which of them forms the base of the address. The chosen segment does not pass through any 16-bit shift. Its bits are wired four positions up into a 20-bit adder, so its top nibble survives. The offset enters the same adder zero-extended as the low operand.

The 20-bit sum goes into a dedicated address latch that drives the external address bus. The latch takes a new value only on a clock edge where the load strobe is high; at all other times the bus holds steady. A synchronous reset clears all segment registers and the latch. Any carry out of the top bit is dropped, so addresses wrap within a 1 MiB space.

Top module: `seg_addr_gen`

## Requirements
- R1: On a rising edge with `addr_load` high, `addr_bus` takes ((segment << 4) + offset) mod 2^20, where the segment is the register picked by `seg_sel` and the offset is zero-extended.
- R2: Segment 0xB000 with offset 0x8000 yields `addr_bus` = 0xB8000.
- R3: A carry out of bit 19 is discarded; segment 0xFFFF with offset 0x0010 yields 0x00000.
- R4: While `addr_load` is low, `addr_bus` keeps its value across clock edges.
- R5: A synchronous reset (`rst` high at a rising edge) clears `addr_bus` and all four segment registers to zero.
- R6: There are four segment registers with indices 0 to 3. On a rising edge with `wr_en` high, register `wr_idx` takes `wr_data`, and the other three do not change.
- R7: While `wr_en` is low, `wr_data` and `wr_idx` have no effect on any segment register.
- R8: Each segment register keeps its upper four bits in the address: segment 0xF000 with offset 0 yields 0xF0000.
- R9: When a write and a load happen on the same edge, the load uses the segment value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Segment register write enable |
| wr_idx | input | 2 | Index of the segment register to write |
| wr_data | input | 16 | Value to write into the segment register |
| seg_sel | input | 2 | Index of the segment register used as the address base |
| offset | input | 16 | Offset added as the low-order operand |
| addr_load | input | 1 | Strobe that loads the computed address into the latch |
| addr_bus | output | 20 | Latched 20-bit physical address |

## Verification
The only observable state is the latched bus value, and the segment registers can be seen only through it. A corrupt segment register shows up on the first load that selects it, one edge after the strobe, with the error confined to bits 4 to 19. A shift that drops the top nibble, or a carry that is kept, shows up at once in the 0xB000, 0xF000 and wrapping cases. A latch that updates without the strobe shows as a bus change on a hold cycle.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int SEL_W = 2,
  localparam int ADDR_W = SEG_W + SHIFT,
  localparam int NSEG = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [OFF_W-1:0]  offset,
  input  logic              addr_load,
  output logic [ADDR_W-1:0] addr_bus
);

  logic [NSEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]           seg_cur;
  logic [ADDR_W-1:0]          base, off_ext, sum;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) seg_q[i] <= '0;
      else if (wr_en && wr_idx == SEL_W'(i)) seg_q[i] <= wr_data;
    end
  end

  assign seg_cur = seg_q[seg_sel];
  // segment lands on adder inputs SHIFT..ADDR_W-1
  assign base    = {seg_cur, {SHIFT{1'b0}}};
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, offset};
  assign sum     = base + off_ext;

  always_ff @(posedge clk) begin
    if (rst) addr_bus <= '0;
    else if (addr_load) addr_bus <= sum;
  end

  assert_low_nibble_R1: assert property (@(posedge clk) disable iff (rst)
    addr_load |=> addr_bus[SHIFT-1:0] == $past(offset[SHIFT-1:0]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !addr_load |=> $stable(addr_bus));

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> (addr_bus == '0 && seg_q == '0));

  assert_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> seg_q[$past(wr_idx)] == $past(wr_data));

  assert_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(seg_q));

endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  seg_sel = '0;
  logic [15:0] offset = '0;
  logic        addr_load = 1'b0;
  logic [19:0] addr_bus;

  int total = 0;
  int bad = 0;
  logic [15:0] mdl [4];

  always #5 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .seg_sel(seg_sel), .offset(offset), .addr_load(addr_load), .addr_bus(addr_bus)
  );

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  task automatic check(input string req, input logic [19:0] exp);
    total++;
    if (addr_bus !== exp) begin
      bad++;
      $display("FAIL %s: addr_bus=%05h expected=%05h", req, addr_bus, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[idx] = v;
  endtask

  task automatic ld(input logic [1:0] sel, input logic [15:0] o);
    @(negedge clk);
    seg_sel = sel; offset = o; addr_load = 1'b1;
    @(negedge clk);
    addr_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check("R5 latch after reset", 20'h0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ld(2'(i), 16'h0000);
      check("R5 segment after reset", 20'h0);
    end

    wr(2'd1, 16'hB000);
    ld(2'd1, 16'h8000);
    check("R2 B000:8000", 20'hB8000);
    wr(2'd2, 16'hFFFF);
    ld(2'd2, 16'h0010);
    check("R3 wrap FFFF:0010", 20'h00000);
    ld(2'd2, 16'hFFFF);
    check("R3 wrap FFFF:FFFF", 20'h0FFEF);
    wr(2'd3, 16'hF000);
    ld(2'd3, 16'h0000);
    check("R8 top nibble kept", 20'hF0000);

    // R4: strobe low, inputs change, bus holds
    @(negedge clk);
    seg_sel = 2'd0; offset = 16'h1234;
    repeat (4) @(negedge clk);
    check("R4 hold without load", 20'hF0000);

    // R7: write with enable low is ignored
    @(negedge clk);
    wr_idx = 2'd3; wr_data = 16'h1111;
    @(negedge clk);
    ld(2'd3, 16'h0005);
    check("R7 disabled write ignored", phys(16'hF000, 16'h0005));

    // R9: write and load on the same edge use the old segment
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'd1; wr_data = 16'h2000;
    seg_sel = 2'd1; offset = 16'h0001; addr_load = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr_load = 1'b0; mdl[1] = 16'h2000;
    check("R9 same-edge uses old segment", 20'hB0001);
    ld(2'd1, 16'h0001);
    check("R9 new segment next load", 20'h20001);

    // R6 and R1: sweep each register with many segment/offset patterns
    for (int k = 0; k < 32; k++) begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] sv;
        sv = 16'(k * 16'h0811) ^ 16'(i * 16'h4000) ^ 16'(k << 11);
        wr(2'(i), sv);
        for (int j = 0; j < 4; j++) begin
          ld(2'(j), 16'h0000);
          check("R6 only indexed register written", phys(mdl[j], 16'h0));
        end
        for (int m = 0; m < 8; m++) begin
          logic [15:0] ov;
          ov = 16'(m * 16'h2493) ^ 16'(k * 16'h0107);
          ld(2'(i), ov);
          check("R1 sum latched", phys(mdl[i], ov));
        end
      end
    end

    // R5: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R5 latch cleared", 20'h0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ld(2'(i), 16'h0007);
      check("R5 segments cleared", 20'h00007);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule